// File: doc/BRIEF.md
# Settings Save and Restore Sequencer

This block keeps three setting bytes of a dual audio attenuator (the two wiper codes and the configuration byte) in a small modelled nonvolatile array, and moves them between that array and the working registers. When a bus write transaction ends with a STOP and the transaction changed a register, the sequencer starts a save cycle. A save always rewrites all three bytes, and `busy_o` stays high for a fixed programming time given in clock cycles. The bus front end uses `busy_o` to refuse its slave address during that time.

If smooth wiper updates are enabled and one is still waiting for its zero crossing, the save is held back until that wait ends. Nothing is saved while the live configuration selects volatile storage. After reset the sequencer drives one load strobe carrying the restore values. The configuration byte always comes from the array. Each wiper comes from the array in nonvolatile mode, and comes back as the mute code of the selected taper in volatile mode.

The array is a plain register model. A separate active-low initialise input sets it to factory contents, so its contents survive ordinary resets.

Top module: `nvs_store`

## Requirements
- R1: In the second clock cycle after `rst_n` is released, `load_o` is high for exactly one cycle and `load_cfg_o` equals the stored configuration byte.
- R2: When bit 2 of the stored configuration byte is 0, `load_w0_o` and `load_w1_o` during the load strobe equal the stored wiper bytes.
- R3: When bit 2 of the stored configuration byte is 1, both restored wipers equal the mute code. The mute code is 33 when bit 0 of that byte is 1, and 63 when bit 0 is 0.
- R4: After `init_n` is pulled low, the array holds the configuration byte 0x87.
- R5: A STOP with `dirty_i` high and `cfg_i[2]` low, and no deferral, makes `busy_o` high from the first cycle after the STOP, for exactly `PROG_CYCLES` consecutive cycles.
- R6: `nv_we_o` is high for exactly one cycle, which is the first cycle of every busy window. In that cycle all three array bytes take `wiper0_i`, `wiper1_i` and `cfg_i`, even if only one of them changed.
- R7: A STOP with `dirty_i` low, or with `cfg_i[2]` high, starts no save: `busy_o` and `nv_we_o` stay low and the array is unchanged.
- R8: If `cfg_i[1]` and `zc_pend_i` are both high when a save is requested, `busy_o` stays low while they stay high. It rises in the first cycle after a clock edge that samples either of them low. With `cfg_i[1]` low, `zc_pend_i` has no effect.
- R9: A STOP that arrives while a save is deferred or busy is ignored. The busy window keeps its length of `PROG_CYCLES`.
- R10: `busy_o` is low during the load strobe, and `load_o` never rises again until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer (power-up) |
| init_n | input | 1 | Active-low asynchronous load of factory contents into the array |
| stop_i | input | 1 | One-cycle strobe: STOP ended a write transaction |
| dirty_i | input | 1 | The ending transaction modified a register |
| zc_pend_i | input | 1 | A smooth wiper update is waiting for its zero crossing |
| cfg_i | input | 8 | Live configuration byte (bit 2 volatile, bit 1 zero-cross enable, bit 0 coarse taper) |
| wiper0_i | input | 6 | Live wiper 0 code |
| wiper1_i | input | 6 | Live wiper 1 code |
| busy_o | output | 1 | Save programming in progress |
| nv_we_o | output | 1 | Array write enable, all three bytes |
| load_o | output | 1 | Restore strobe after reset |
| load_w0_o | output | 6 | Restored wiper 0 code |
| load_w1_o | output | 6 | Restored wiper 1 code |
| load_cfg_o | output | 8 | Restored configuration byte |

## Verification
On every cycle, the bound checker confirms four things. Each busy window lasts exactly the programming time. The write enable fires only in the first busy cycle. A busy window never opens on an edge that sampled an active zero-crossing wait. The load strobe is a single cycle and never overlaps busy. The bench scenarios have to show the rest. These are the restored values, both from factory contents and after a save, the mute substitution in volatile mode, and saves that must not happen. They also cover the ignored STOPs and the exact cycle in which a deferred save starts.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    localparam int BYTE_W     = 8;
    localparam int WIPER_W    = 6;
    localparam int N_SLOTS    = 3;

    // slot order inside the array
    localparam int SLOT_W0    = 0;
    localparam int SLOT_W1    = 1;
    localparam int SLOT_CFG   = 2;

    // configuration byte fields
    localparam int CFG_VOL_BIT   = 2;
    localparam int CFG_ZC_BIT    = 1;
    localparam int CFG_TAPER_BIT = 0;

    localparam logic [BYTE_W-1:0]  FACTORY_CFG   = 8'h87;
    localparam logic [BYTE_W-1:0]  FACTORY_WIPER = 8'h00;
    localparam logic [WIPER_W-1:0] MUTE_FINE     = 6'd63;
    localparam logic [WIPER_W-1:0] MUTE_COARSE   = 6'd33;

    typedef enum logic [2:0] {
        ST_RST,
        ST_LOAD,
        ST_IDLE,
        ST_HOLD,
        ST_PROG
    } seq_state_e;

    function automatic logic [BYTE_W-1:0] factory_slot(input int idx);
        return (idx == SLOT_CFG) ? FACTORY_CFG : FACTORY_WIPER;
    endfunction

    function automatic logic [WIPER_W-1:0] mute_code(input logic coarse);
        return coarse ? MUTE_COARSE : MUTE_FINE;
    endfunction

endpackage

// File: rtl/nvs_array.sv
module nvs_array
    import nvs_pkg::*;
(
    input  logic                             clk,
    input  logic                             init_n,
    input  logic                             we,
    input  logic [N_SLOTS-1:0][BYTE_W-1:0]   wdata,
    output logic [N_SLOTS-1:0][BYTE_W-1:0]   rdata
);

    // One register per slot; every write refreshes all of them together.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic [BYTE_W-1:0] cell_q;

        always_ff @(posedge clk or negedge init_n) begin
            if (!init_n) begin
                cell_q <= factory_slot(s);
            end else if (we) begin
                cell_q <= wdata[s];
            end
        end

        assign rdata[s] = cell_q;
    end

endmodule

// File: rtl/nvs_restore_map.sv
module nvs_restore_map
    import nvs_pkg::*;
(
    input  logic [N_SLOTS-1:0][BYTE_W-1:0] stored,
    output logic [WIPER_W-1:0]             w0,
    output logic [WIPER_W-1:0]             w1,
    output logic [BYTE_W-1:0]              cfg
);

    logic volatile_mode;
    logic unused_hi;

    assign cfg           = stored[SLOT_CFG];
    assign volatile_mode = cfg[CFG_VOL_BIT];
    assign unused_hi     = ^{stored[SLOT_W0][BYTE_W-1:WIPER_W],
                             stored[SLOT_W1][BYTE_W-1:WIPER_W]};

    always_comb begin
        if (volatile_mode) begin
            w0 = mute_code(cfg[CFG_TAPER_BIT]);
            w1 = mute_code(cfg[CFG_TAPER_BIT]);
        end else begin
            w0 = stored[SLOT_W0][WIPER_W-1:0];
            w1 = stored[SLOT_W1][WIPER_W-1:0];
        end
    end

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic dirty_i,
    input  logic zc_pend_i,
    input  logic vol_mode,
    input  logic zc_en,
    output logic busy,
    output logic we,
    output logic load
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic save_req;
    logic defer;

    assign save_req = stop_i && dirty_i && !vol_mode;
    assign defer    = zc_en && zc_pend_i;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_RST:  seq_d.st = ST_LOAD;
            ST_LOAD: seq_d.st = ST_IDLE;
            ST_IDLE: begin
                if (save_req) begin
                    if (defer) begin
                        seq_d.st = ST_HOLD;
                    end else begin
                        seq_d.st  = ST_PROG;
                        seq_d.cnt = CNT_LAST;
                    end
                end
            end
            ST_HOLD: begin
                if (!defer) begin
                    seq_d.st  = ST_PROG;
                    seq_d.cnt = CNT_LAST;
                end
            end
            ST_PROG: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_RST, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.st == ST_PROG);
    assign we   = busy && (seq_q.cnt == CNT_LAST);
    assign load = (seq_q.st == ST_LOAD);

endmodule

// File: rtl/nvs_store.sv
module nvs_store
    import nvs_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_n,
    input  logic               stop_i,
    input  logic               dirty_i,
    input  logic               zc_pend_i,
    input  logic [7:0]         cfg_i,
    input  logic [5:0]         wiper0_i,
    input  logic [5:0]         wiper1_i,
    output logic               busy_o,
    output logic               nv_we_o,
    output logic               load_o,
    output logic [5:0]         load_w0_o,
    output logic [5:0]         load_w1_o,
    output logic [7:0]         load_cfg_o
);

    logic [N_SLOTS-1:0][BYTE_W-1:0] wr_bytes;
    logic [N_SLOTS-1:0][BYTE_W-1:0] rd_bytes;
    logic                           unused_cfg;

    assign unused_cfg = ^{cfg_i[7:3], cfg_i[CFG_TAPER_BIT]};

    assign wr_bytes[SLOT_W0]  = {{(BYTE_W-WIPER_W){1'b0}}, wiper0_i};
    assign wr_bytes[SLOT_W1]  = {{(BYTE_W-WIPER_W){1'b0}}, wiper1_i};
    assign wr_bytes[SLOT_CFG] = cfg_i;

    nvs_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_i    (stop_i),
        .dirty_i   (dirty_i),
        .zc_pend_i (zc_pend_i),
        .vol_mode  (cfg_i[CFG_VOL_BIT]),
        .zc_en     (cfg_i[CFG_ZC_BIT]),
        .busy      (busy_o),
        .we        (nv_we_o),
        .load      (load_o)
    );

    nvs_array u_array (
        .clk    (clk),
        .init_n (init_n),
        .we     (nv_we_o),
        .wdata  (wr_bytes),
        .rdata  (rd_bytes)
    );

    nvs_restore_map u_map (
        .stored (rd_bytes),
        .w0     (load_w0_o),
        .w1     (load_w1_o),
        .cfg    (load_cfg_o)
    );

endmodule

// File: rtl/nvs_store_chk.sv
module nvs_store_chk #(
    parameter int PROG_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic zc_en,
    input logic zc_pend,
    input logic busy,
    input logic we,
    input logic load
);

    localparam int RUN_W = $clog2(PROG_CYCLES + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == RUN_W'(PROG_CYCLES));

    // R6
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> busy);

    // R6
    we_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> we);

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R8
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !($past(zc_en) && $past(zc_pend)));

    // R10
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R10
    load_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

bind nvs_store nvs_store_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .zc_en   (cfg_i[1]),
    .zc_pend (zc_pend_i),
    .busy    (busy_o),
    .we      (nv_we_o),
    .load    (load_o)
);

// File: tb/nvs_store_tb.sv
module nvs_store_tb;

    localparam int PROG = 8;

    logic       clk = 1'b0;
    logic       rst_n, init_n, stop_i, dirty_i, zc_pend_i;
    logic [7:0] cfg_i;
    logic [5:0] wiper0_i, wiper1_i;
    logic       busy_o, nv_we_o, load_o;
    logic [5:0] load_w0_o, load_w1_o;
    logic [7:0] load_cfg_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    nvs_store #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .stop_i(stop_i),
        .dirty_i(dirty_i), .zc_pend_i(zc_pend_i), .cfg_i(cfg_i),
        .wiper0_i(wiper0_i), .wiper1_i(wiper1_i), .busy_o(busy_o),
        .nv_we_o(nv_we_o), .load_o(load_o), .load_w0_o(load_w0_o),
        .load_w1_o(load_w1_o), .load_cfg_o(load_cfg_o)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Leaves the bench in the load strobe cycle.
    task automatic do_reset(input bit factory);
        rst_n  = 1'b0;
        init_n = factory ? 1'b0 : 1'b1;
        stop_i = 1'b0;
        tick();
        tick();
        init_n = 1'b1;
        rst_n  = 1'b1;
        tick();
        chk("R1 load strobe", load_o, 1);
        chk("R10 busy at load", busy_o, 0);
    endtask

    task automatic restore_check(input int cfg, input int w0, input int w1, input string tag);
        do_reset(1'b0);
        chk({tag, " cfg"}, load_cfg_o, cfg);
        chk({tag, " w0"}, load_w0_o, w0);
        chk({tag, " w1"}, load_w1_o, w1);
        tick();
        chk("R10 load once", load_o, 0);
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        tick();
        stop_i = 1'b0;
    endtask

    // Starts in the first cycle after the STOP (or after deferral clears).
    task automatic measure_busy(input int inject_at, input string tag);
        int busy_n  = 0;
        int we_n    = 0;
        int we_head = 0;
        for (int i = 0; i < PROG + 4; i++) begin
            if (busy_o) busy_n++;
            if (nv_we_o) begin
                we_n++;
                if (i == 0) we_head = 1;
            end
            stop_i = (i == inject_at);
            tick();
        end
        stop_i = 1'b0;
        chk({tag, " busy length"}, busy_n, PROG);
        chk("R6 single write", we_n, 1);
        chk("R6 write in first busy cycle", we_head, 1);
    endtask

    task automatic t_factory();
        do_reset(1'b1);
        chk("R4 factory cfg", load_cfg_o, 8'h87);
        chk("R3 mute w0", load_w0_o, 33);
        chk("R3 mute w1", load_w1_o, 33);
        tick();
        chk("R10 load once", load_o, 0);
        chk("R7 idle busy", busy_o, 0);
    endtask

    task automatic t_save();
        cfg_i = 8'h80; wiper0_i = 6'd21; wiper1_i = 6'd42; dirty_i = 1'b1;
        pulse_stop();
        chk("R5 busy first cycle", busy_o, 1);
        measure_busy(-1, "R5");
        wiper0_i = 6'd0; wiper1_i = 6'd0;
        restore_check(8'h80, 21, 42, "R2 R6 restore");
    endtask

    task automatic t_nosave();
        wiper0_i = 6'd5; dirty_i = 1'b0; cfg_i = 8'h80;
        pulse_stop();
        for (int i = 0; i < 4; i++) begin
            chk("R7 clean stop busy", busy_o, 0);
            chk("R7 clean stop we", nv_we_o, 0);
            tick();
        end
        dirty_i = 1'b1; cfg_i = 8'h84;
        pulse_stop();
        for (int i = 0; i < 4; i++) begin
            chk("R7 volatile stop busy", busy_o, 0);
            tick();
        end
        restore_check(8'h80, 21, 42, "R7 array unchanged");
    endtask

    task automatic t_defer();
        cfg_i = 8'h82; zc_pend_i = 1'b1; dirty_i = 1'b1;
        wiper0_i = 6'd7; wiper1_i = 6'd9;
        pulse_stop();
        for (int i = 0; i < 5; i++) begin
            chk("R8 held while pending", busy_o, 0);
            stop_i = (i == 2);
            tick();
        end
        stop_i = 1'b0;
        zc_pend_i = 1'b0;
        chk("R8 still held at release", busy_o, 0);
        tick();
        chk("R8 busy after release", busy_o, 1);
        measure_busy(-1, "R8 R9");
        cfg_i = 8'h80; zc_pend_i = 1'b1; wiper0_i = 6'd11;
        pulse_stop();
        chk("R8 pending ignored when disabled", busy_o, 1);
        measure_busy(-1, "R8");
        zc_pend_i = 1'b0;
        restore_check(8'h80, 11, 9, "R8 restore");
    endtask

    task automatic t_restart();
        cfg_i = 8'h80; dirty_i = 1'b1; wiper1_i = 6'd30;
        pulse_stop();
        measure_busy(3, "R9 stop in busy");
        restore_check(8'h80, 11, 30, "R9 restore");
    endtask

    initial begin
        rst_n = 1'b0; init_n = 1'b0; stop_i = 1'b0; dirty_i = 1'b0;
        zc_pend_i = 1'b0; cfg_i = 8'h87; wiper0_i = '0; wiper1_i = '0;
        t_factory();
        t_save();
        t_nosave();
        t_defer();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule